// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave control port for a small bank of configuration registers. A host talks to it over three wires: an active-low frame strobe, a serial clock and a data line. The data line is split into an input pin plus an output pin with its own enable, so a pad ring can build the bidirectional pin. Every frame opens with a direction flag and a three-bit register address. A write frame then carries nine data bits. A read frame has the port return the nine stored bits.

The port runs on a fast system clock. It passes the three serial pins through a synchronizer and finds the serial clock edges by comparing consecutive samples. The eight nine-bit registers drive parallel outputs for the rest of the chip:

- address 0: a configuration word
- address 1: a channel-selection word
- addresses 2 to 4: three six-bit gain codes
- addresses 5 to 7: three sign-magnitude offset codes

Unused bit positions are held at zero.

Top module: `srp_serial_regs`

## Requirements
- R1: A frame lasts exactly while `ser_load_n` is low. Raising it ends the frame and resets the bit position, so the next frame starts again at its first bit.
- R2: Write frame: the port samples `ser_din` on each rising edge of `ser_clk`. The slots are, in order:
  - slot 0: the direction flag, 0 for a write;
  - slots 1 to 3: address bits, most significant first;
  - slots 4 and 5: two ignored bits;
  - slots 6 to 14: data bits 8 down to 0.
  The addressed register is updated after the fifteenth rising edge.
- R3: Read frame: slot 0 is 1 and slots 1 to 3 carry the address. Slots 4 to 6 are ignored. The port then presents data bits 8 down to 0 on `ser_dout` in slots 7 to 15, and changes the bit on each falling edge of `ser_clk`.
- R4: Address map: 0 drives `cfg_o`, 1 drives `mux_o`, 2/3/4 drive `gain_r_o`/`gain_g_o`/`gain_b_o`, and 5/6/7 drive `ofs_r_o`/`ofs_g_o`/`ofs_b_o`. A read returns the same value as the parallel output.
- R5: The configuration word resets to 0x078. The bit layout is:
  - bit 7: full-scale range, reset 0;
  - bit 6: internal reference on;
  - bit 5: three-channel mode;
  - bit 4: correlated sampling;
  - bit 3: high clamp bias;
  - bit 2: power-down, reset 0.
- R6: The channel-selection word resets to 0x0C0. Bit 7 selects the red-first order and bits 6/5/4 select red/green/blue single-channel.
- R7: All gain and offset registers reset to zero.
- R8: Reserved bits are forced to zero on write and read back as zero. The writable masks are:
  - configuration: 0x0FC
  - channel selection: 0x0F0
  - gain: 0x03F
  - offset: 0x1FF (all nine bits, bit 8 being the sign)
- R9: Setting the power-down bit (configuration bit 2) leaves every other register's contents unchanged. Those registers remain writable and readable.
- R10: A frame whose strobe rises before the fifteenth rising edge leaves all registers unchanged.
- R11: `ser_doe` is 1 only during the read data slots (from the falling edge after slot 6 to the falling edge after slot 15). At all other times it is 0, including after a frame ends.
- R12: A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_load_n | input | 1 | Frame strobe, low during a frame |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| ser_doe | output | 1 | Drive enable for the data pin |
| cfg_o | output | 9 | Configuration word |
| mux_o | output | 9 | Channel-selection word |
| gain_r_o | output | 9 | Red gain code |
| gain_g_o | output | 9 | Green gain code |
| gain_b_o | output | 9 | Blue gain code |
| ofs_r_o | output | 9 | Red offset code |
| ofs_g_o | output | 9 | Green offset code |
| ofs_b_o | output | 9 | Blue offset code |

## Verification
A serial pin change passes through two synchronizer flops and one edge register. A read bit therefore reaches `ser_dout` and `ser_doe` three system clocks after the falling edge of `ser_clk`. A write reaches the parallel outputs four system clocks after the fifteenth rising edge. The bench holds every serial clock phase for eight system clocks. It samples read bits at the end of the low phase, just before the next rising edge, and checks the parallel outputs only after the strobe has been high for thirty-two clocks. No check therefore lands inside these short pipeline windows.

// File: rtl/srp_pkg.sv
package srp_pkg;

   localparam int REG_W  = 9;
   localparam int ADDR_W = 3;
   localparam int REG_N  = 1 << ADDR_W;

   typedef enum logic [ADDR_W-1:0] {
      A_CFG    = 3'd0,
      A_MUX    = 3'd1,
      A_GAIN_R = 3'd2,
      A_GAIN_G = 3'd3,
      A_GAIN_B = 3'd4,
      A_OFS_R  = 3'd5,
      A_OFS_G  = 3'd6,
      A_OFS_B  = 3'd7
   } reg_addr_e;

   // Power-on contents per register slot.
   function automatic logic [REG_W-1:0] reset_val(input int idx);
      case (idx)
         0:       return 9'h078;
         1:       return 9'h0C0;
         default: return 9'h000;
      endcase
   endfunction

   // Bits that a write may set; the rest stay zero.
   function automatic logic [REG_W-1:0] wr_mask(input int idx);
      case (idx)
         0:          return 9'h0FC;
         1:          return 9'h0F0;
         2, 3, 4:    return 9'h03F;
         default:    return 9'h1FF;
      endcase
   endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/srp_frame.sv
module srp_frame #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 9,
   parameter int WR_GAP = 2,
   parameter int RD_GAP = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n_s,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              dout,
   output logic              doe
);

   localparam int WR_LEN   = 1 + ADDR_W + WR_GAP + DATA_W;
   localparam int RD_FIRST = 1 + ADDR_W + RD_GAP;
   localparam int RD_LAST  = RD_FIRST + DATA_W;
   localparam int CNT_W    = $clog2(RD_LAST + 2);
   localparam logic [CNT_W-1:0] C_WR_END = CNT_W'(WR_LEN - 1);
   localparam logic [CNT_W-1:0] C_RD_GO  = CNT_W'(RD_FIRST);
   localparam logic [CNT_W-1:0] C_RD_END = CNT_W'(RD_LAST);
   localparam logic [CNT_W-1:0] C_A_LO   = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_A_HI   = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] C_MAX    = {CNT_W{1'b1}};

   logic                sclk_d;
   logic                rise, fall, active;
   logic [CNT_W-1:0]    cnt;
   logic                rw_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-2:0]   sh_in;
   logic [DATA_W-1:0]   sh_out;

   assign active = ~load_n_s;
   assign rise   = sclk_s & ~sclk_d;
   assign fall   = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   // Input side: bit counter, direction flag, address and data shift.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         rw_q   <= 1'b0;
         addr_q <= '0;
         sh_in  <= '0;
      end else if (!active) begin
         cnt <= '0;
      end else if (rise) begin
         if (cnt != C_MAX) cnt <= cnt + 1'b1;
         if (cnt == '0) rw_q <= din_s;
         if (cnt >= C_A_LO && cnt <= C_A_HI)
            addr_q <= {addr_q[ADDR_W-2:0], din_s};
         sh_in <= {sh_in[DATA_W-3:0], din_s};
      end
   end

   // Write commit, one cycle after the last data bit is seen.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= active && rise && !rw_q && (cnt == C_WR_END);
         if (active && rise && (cnt == C_WR_END)) begin
            wr_addr <= addr_q;
            wr_data <= {sh_in, din_s};
         end
      end
   end

   assign rd_addr = addr_q;

   // Output side: launch on falling serial edges during read slots.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         doe    <= 1'b0;
         dout   <= 1'b0;
         sh_out <= '0;
      end else if (!active) begin
         doe  <= 1'b0;
         dout <= 1'b0;
      end else if (fall && rw_q) begin
         if (cnt == C_RD_GO) begin
            doe    <= 1'b1;
            dout   <= rd_data[DATA_W-1];
            sh_out <= {rd_data[DATA_W-2:0], 1'b0};
         end else if (cnt > C_RD_GO && cnt < C_RD_END) begin
            dout   <= sh_out[DATA_W-1];
            sh_out <= {sh_out[DATA_W-2:0], 1'b0};
         end else if (cnt >= C_RD_END) begin
            doe  <= 1'b0;
            dout <= 1'b0;
         end
      end
   end

   assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   assert_drive_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      doe |-> rw_q);

   assert_release_on_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_n_s) |=> !doe);

endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat
);

   localparam int NREG = 1 << ADDR_W;

   logic [DATA_W-1:0] regs [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         localparam logic [DATA_W-1:0] RV = DATA_W'(srp_pkg::reset_val(i));
         localparam logic [DATA_W-1:0] WM = DATA_W'(srp_pkg::wr_mask(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= RV;
            else if (wr_en && wr_addr == ADDR_W'(i))
               regs[i] <= wr_data & WM;
         end

         assign regs_flat[i*DATA_W +: DATA_W] = regs[i];

         assert_hold_unaddressed_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(regs[i]));
      end
   endgenerate

   assign rd_data = regs[rd_addr];

endmodule

// File: rtl/srp_serial_regs.sv
module srp_serial_regs #(
   parameter int ADDR_W      = srp_pkg::ADDR_W,
   parameter int DATA_W      = srp_pkg::REG_W,
   parameter int SYNC_STAGES = 2,
   parameter int WR_GAP      = 2,
   parameter int RD_GAP      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_load_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              ser_doe,
   output logic [DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0] mux_o,
   output logic [DATA_W-1:0] gain_r_o,
   output logic [DATA_W-1:0] gain_g_o,
   output logic [DATA_W-1:0] gain_b_o,
   output logic [DATA_W-1:0] ofs_r_o,
   output logic [DATA_W-1:0] ofs_g_o,
   output logic [DATA_W-1:0] ofs_b_o
);

   import srp_pkg::*;

   localparam int NREG = 1 << ADDR_W;

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("DATA_W must match the package register width");
      end
      if (ADDR_W != srp_pkg::ADDR_W) begin : g_bad_addr
         $error("ADDR_W must match the package address width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WR_GAP < 0 || RD_GAP < 1) begin : g_bad_gap
         $error("gap lengths out of range");
      end
   endgenerate

   logic load_n_s, sclk_s, din_s;

   srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
      .clk(clk), .rst_n(rst_n), .d_i(ser_load_n), .q_o(load_n_s));
   srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_i(ser_clk), .q_o(sclk_s));
   srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d_i(ser_din), .q_o(din_s));

   logic [ADDR_W-1:0]      rd_addr, wr_addr;
   logic [DATA_W-1:0]      rd_data, wr_data;
   logic                   wr_en;
   logic [NREG*DATA_W-1:0] regs_flat;

   srp_frame #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_GAP(WR_GAP), .RD_GAP(RD_GAP)
   ) u_frame (
      .clk(clk), .rst_n(rst_n),
      .load_n_s(load_n_s), .sclk_s(sclk_s), .din_s(din_s),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dout(ser_dout), .doe(ser_doe)
   );

   srp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .regs_flat(regs_flat)
   );

   assign cfg_o    = regs_flat[int'(A_CFG)    * DATA_W +: DATA_W];
   assign mux_o    = regs_flat[int'(A_MUX)    * DATA_W +: DATA_W];
   assign gain_r_o = regs_flat[int'(A_GAIN_R) * DATA_W +: DATA_W];
   assign gain_g_o = regs_flat[int'(A_GAIN_G) * DATA_W +: DATA_W];
   assign gain_b_o = regs_flat[int'(A_GAIN_B) * DATA_W +: DATA_W];
   assign ofs_r_o  = regs_flat[int'(A_OFS_R)  * DATA_W +: DATA_W];
   assign ofs_g_o  = regs_flat[int'(A_OFS_G)  * DATA_W +: DATA_W];
   assign ofs_b_o  = regs_flat[int'(A_OFS_B)  * DATA_W +: DATA_W];

endmodule

// File: tb/srp_serial_regs_test.sv
module srp_serial_regs_test;

   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_load_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
   logic ser_dout, ser_doe;
   logic [8:0] cfg_o, mux_o, gain_r_o, gain_g_o, gain_b_o, ofs_r_o, ofs_g_o, ofs_b_o;

   int checks = 0;
   int errors = 0;
   logic [8:0] mdl [8];

   always #10 clk = ~clk;

   srp_serial_regs uut (
      .clk(clk), .rst_n(rst_n),
      .ser_load_n(ser_load_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_dout(ser_dout), .ser_doe(ser_doe),
      .cfg_o(cfg_o), .mux_o(mux_o),
      .gain_r_o(gain_r_o), .gain_g_o(gain_g_o), .gain_b_o(gain_b_o),
      .ofs_r_o(ofs_r_o), .ofs_g_o(ofs_g_o), .ofs_b_o(ofs_b_o)
   );

   function automatic logic [8:0] exp_reset(input int a);
      if (a == 0) return 9'h078;
      if (a == 1) return 9'h0C0;
      return 9'h000;
   endfunction

   function automatic logic [8:0] exp_mask(input int a);
      if (a == 0) return 9'h0FC;
      if (a == 1) return 9'h0F0;
      if (a <= 4) return 9'h03F;
      return 9'h1FF;
   endfunction

   function automatic logic [8:0] port_val(input int a);
      case (a)
         0: return cfg_o;     1: return mux_o;
         2: return gain_r_o;  3: return gain_g_o;
         4: return gain_b_o;  5: return ofs_r_o;
         6: return ofs_g_o;   default: return ofs_b_o;
      endcase
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_h(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_all(input string req);
      for (int a = 0; a < 8; a++) check(req, port_val(a), mdl[a]);
   endtask

   // Sends the first nrise slots of a write frame; 15 makes it complete.
   task automatic write_frame(input int a, input logic [8:0] d, input int nrise);
      logic [14:0] bits;
      bits = {1'b0, 3'(a), 2'($urandom), d};
      ser_load_n = 1'b0;
      wait_h(H);
      for (int k = 0; k < nrise; k++) begin
         ser_din = bits[14-k];
         wait_h(H);
         ser_clk = 1'b1;
         wait_h(H);
         ser_clk = 1'b0;
      end
      wait_h(H);
      ser_load_n = 1'b1;
      wait_h(4*H);
   endtask

   task automatic read_frame(input int a, output logic [8:0] got,
                             output logic early_oe, output logic gap_oe, output logic late_oe);
      logic [3:0] hdr;
      hdr = {1'b1, 3'(a)};
      got = '0; early_oe = 1'b0; gap_oe = 1'b0; late_oe = 1'b0;
      ser_load_n = 1'b0;
      wait_h(H);
      for (int k = 0; k < 16; k++) begin
         ser_din = (k < 4) ? hdr[3-k] : 1'($urandom);
         wait_h(H);
         if (k < 7) begin
            if (ser_doe) early_oe = 1'b1;
         end else begin
            got = {got[7:0], ser_dout};
            if (!ser_doe) gap_oe = 1'b1;
         end
         ser_clk = 1'b1;
         wait_h(H);
         ser_clk = 1'b0;
      end
      wait_h(H);
      late_oe = ser_doe;
      ser_load_n = 1'b1;
      wait_h(4*H);
      if (ser_doe) late_oe = 1'b1;
   endtask

   task automatic read_check(input string req, input int a);
      logic [8:0] got;
      logic e, g, l;
      read_frame(a, got, e, g, l);
      check(req, got, mdl[a]);
      check("R11 drive enable", {6'd0, e, g, l}, 9'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [8:0] d;
      int a, n;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) mdl[i] = exp_reset(i);
      wait_h(5);
      rst_n = 1'b1;
      wait_h(4);

      // R5 R6 R7: reset contents; R11 idle line
      check("R5 config reset", cfg_o, 9'h078);
      check("R6 mux reset", mux_o, 9'h0C0);
      check_all("R7 reset state");
      check("R11 idle enable", {8'd0, ser_doe}, 9'd0);

      // R3 R4: read every address at reset
      for (int i = 0; i < 8; i++) read_check("R3 R4 reset readback", i);

      // R8: all-ones write shows the writable mask, R4 map by distinct values
      for (int i = 0; i < 8; i++) begin
         write_frame(i, 9'h1FF, 15);
         mdl[i] = exp_mask(i);
         check("R8 reserved bits zero", port_val(i), exp_mask(i));
      end
      for (int i = 0; i < 8; i++) begin
         d = 9'(i * 37 + 5);
         write_frame(i, d, 15);
         mdl[i] = d & exp_mask(i);
      end
      check_all("R4 address map");
      for (int i = 0; i < 8; i++) read_check("R4 read matches output", i);

      // R9: power-down bit leaves others intact and writable
      write_frame(0, mdl[0] | 9'h004, 15);
      mdl[0] = (mdl[0] | 9'h004) & exp_mask(0);
      check_all("R9 contents kept in power-down");
      write_frame(6, 9'h155, 15);
      mdl[6] = 9'h155;
      check("R9 writable in power-down", ofs_g_o, 9'h155);
      read_check("R9 readable in power-down", 6);

      // R10 R1: truncated frames, then a full frame works
      for (int t = 1; t < 15; t++) begin
         write_frame(t % 8, ~mdl[t % 8], t);
      end
      check_all("R10 truncated frame ignored");
      write_frame(3, 9'h02A, 15);
      mdl[3] = 9'h02A;
      check("R1 frame restarts after abort", gain_g_o, 9'h02A);

      // R2 R12 R3: random traffic
      for (int it = 0; it < 40; it++) begin
         a = int'($urandom_range(0, 7));
         d = 9'($urandom);
         n = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 14)) : 15;
         write_frame(a, d, n);
         if (n == 15) mdl[a] = d & exp_mask(a);
         check_all(n == 15 ? "R2 R12 random write" : "R10 random truncation");
         read_check("R3 random read", int'($urandom_range(0, 7)));
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule